// File: doc/BRIEF.md
# Windowed Assertion-Time Percentage Monitor

This block watches two active-low thermal event inputs and measures how much of a programmable time window each one spends asserted. Every window is cut into 256 equal sample slots. At the end of each slot the input level is sampled, and each asserted sample adds one to a running count. The count saturates at 255, so the result reads as an 8-bit fraction of the window: 0x00 is never asserted and 0xFF is asserted the whole time. At every window boundary the count is copied into a readable on-time register and the running count restarts from zero.

The length of a slot is set by a per-channel 3-bit window code. The code scales a slow sample tick into six window lengths, doubling at each step. The running count is compared at all times against a per-channel 8-bit limit. When the count goes above the limit, a sticky percentage status bit is set, and the combined alert output is raised unless that channel's mask bit is set. A separate sticky bit records each high-to-low edge on an input. Software reaches all of this through a small single-cycle register port. Reading the status register clears it.

Top module: `thermal_duty_monitor`

## Requirements
- R1: Register 0 holds the window codes: channel 0 in bits [4:2] and channel 1 in bits [7:5]. Bits [1:0] read as 0. Register 5 holds the mask bits (bit 0 for channel 0, bit 1 for channel 1, upper bits read 0). Registers 1 and 2 are the 8-bit limits of channels 0 and 1. Registers 3 and 4 are their on-time values. Register 6 is status and register 7 reads 0.
- R2: A slot lasts SLOT_TICKS_MIN << min(code,5) sample ticks, so codes 5, 6 and 7 all give the longest window. A window is 256 slots.
- R3: At each slot end, the running count of a channel increases by one if its input is low, and stops at 255. At the end of the 256th slot, the updated count is written into that channel's on-time register and the running count is cleared.
- R4: A channel's percentage status bit is set on the cycle after its running count is strictly greater than its limit. A limit of 0x00 therefore trips on the first asserted sample, and a limit of 0xFF never trips.
- R5: A channel's event status bit is set on the cycle after its input goes from high to low.
- R6: alert is high exactly when some channel has its percentage status bit set and its mask bit clear.
- R7: Status register 6 packs event bits in [1:0] and percentage bits in [3:2], one bit per channel in channel order. A read of register 6 clears those bits. A set condition in the same cycle as the read leaves its bit set.
- R8: A write to register 0 that changes a channel's window code restarts that channel's slot timer and clears its running count. The channel's on-time register keeps its value. A write that leaves a code unchanged does not disturb that channel.
- R9: Writes to registers 3, 4, 6 and 7 have no effect on any readable value.
- R10: After reset, the codes, running counts, on-time values, masks and status bits are 0, both limits are 0xFF, and alert is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the slow sample time base |
| evt_n | input | 2 | Synchronized active-low event inputs, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when addressing register 6) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| alert | output | 1 | Combined unmasked percentage alert |

## Verification
Some properties are checked on every cycle. A percentage bit may rise only after the count exceeded the limit. A limit of 0xFF never lets that bit rise. The running count moves only by one step or back to zero. The on-time value changes only at a window end. A restart empties the count. Edges and status reads leave exactly the status the rules demand.

Other behaviours can only be shown by the bench scenarios, using its behavioural model. These are the absolute on-time values across different window codes, the saturation at 0xFF, the first-sample trip with a zero limit, masking of the alert, and the collisions between a read and a set.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int TDM_NCH    = 2;
   localparam int CODE_W     = 3;
   localparam int CFG_LSB    = 2;
   localparam int MAX_SHIFT  = 5;
   localparam int VAL_W      = 8;
   localparam int SLOT_IDX_W = 8;
   localparam int ADDR_W     = 3;

   localparam logic [ADDR_W-1:0] RA_CFG  = 3'd0;
   localparam logic [ADDR_W-1:0] RA_LIM0 = 3'd1;
   localparam logic [ADDR_W-1:0] RA_ONT0 = 3'd3;
   localparam logic [ADDR_W-1:0] RA_MASK = 3'd5;
   localparam logic [ADDR_W-1:0] RA_STAT = 3'd6;

   typedef logic [VAL_W-1:0]  val_t;
   typedef logic [CODE_W-1:0] wcode_t;

   function automatic int unsigned code_shift(wcode_t c);
      return (int'(c) > MAX_SHIFT) ? MAX_SHIFT : int'(c);
   endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
   import tdm_pkg::*;
#(
   parameter int SLOT_TICKS_MIN = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   restart,
   input  wcode_t code,
   output logic   slot_end,
   output logic   win_end
);
   localparam int MAXLEN = SLOT_TICKS_MIN << MAX_SHIFT;
   localparam int TCW    = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;

   logic [TCW-1:0]        tc_q;
   logic [TCW-1:0]        len_m1;
   logic [SLOT_IDX_W-1:0] si_q;

   always_comb len_m1 = TCW'((SLOT_TICKS_MIN << code_shift(code)) - 1);

   assign slot_end = tick && (tc_q == len_m1);
   assign win_end  = slot_end && (si_q == {SLOT_IDX_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= '0;
         si_q <= '0;
      end else if (restart) begin
         tc_q <= '0;
         si_q <= '0;
      end else if (tick) begin
         if (tc_q == len_m1) begin
            tc_q <= '0;
            si_q <= si_q + 1'b1;
         end else begin
            tc_q <= tc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tdm_channel_acc.sv
module tdm_channel_acc
   import tdm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic evt_n,
   input  logic restart,
   input  logic slot_end,
   input  logic win_end,
   input  val_t limit,
   output val_t cnt_q,
   output val_t ont_q,
   output logic over,
   output logic fall
);
   logic prev_q;
   val_t nxt;

   always_comb begin
      if (!evt_n && (cnt_q != {VAL_W{1'b1}})) nxt = cnt_q + 1'b1;
      else                                    nxt = cnt_q;
   end

   assign over = (cnt_q > limit);
   assign fall = prev_q & ~evt_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ont_q  <= '0;
         prev_q <= 1'b1;
      end else begin
         prev_q <= evt_n;
         if (restart) begin
            cnt_q <= '0;
         end else if (slot_end) begin
            if (win_end) begin
               ont_q <= nxt;
               cnt_q <= '0;
            end else begin
               cnt_q <= nxt;
            end
         end
      end
   end
endmodule

// File: rtl/tdm_regs.sv
module tdm_regs
   import tdm_pkg::*;
#(
   parameter int NCH = TDM_NCH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  val_t                       wdata,
   input  logic [NCH-1:0][VAL_W-1:0]  ontime,
   input  logic [NCH-1:0]             over,
   input  logic [NCH-1:0]             fall,
   output logic [NCH-1:0][CODE_W-1:0] code_q,
   output logic [NCH-1:0][VAL_W-1:0]  limit_q,
   output logic [NCH-1:0]             restart,
   output logic [NCH-1:0]             ev_q,
   output logic [NCH-1:0]             pct_q,
   output logic [NCH-1:0]             mask_q,
   output val_t                       rdata,
   output logic                       alert
);
   logic wr_cfg;
   logic clr;

   assign wr_cfg = wr_en && (addr == RA_CFG);
   assign clr    = rd_en && (addr == RA_STAT);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY_LIM = RA_LIM0 + ADDR_W'(c);
      wcode_t new_code;
      assign new_code   = wdata[CFG_LSB + CODE_W*c +: CODE_W];
      assign restart[c] = wr_cfg && (new_code != code_q[c]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[c]  <= '0;
            limit_q[c] <= {VAL_W{1'b1}};
         end else if (wr_en) begin
            if (addr == RA_CFG) code_q[c]  <= new_code;
            if (addr == MY_LIM) limit_q[c] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ev_q   <= '0;
         pct_q  <= '0;
      end else begin
         if (wr_en && (addr == RA_MASK)) mask_q <= wdata[NCH-1:0];
         ev_q  <= (clr ? '0 : ev_q)  | fall;
         pct_q <= (clr ? '0 : pct_q) | over;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == RA_CFG) begin
         for (int c = 0; c < NCH; c++) rdata[CFG_LSB + CODE_W*c +: CODE_W] = code_q[c];
      end
      if (addr == RA_MASK) rdata = VAL_W'(mask_q);
      if (addr == RA_STAT) rdata = VAL_W'({pct_q, ev_q});
      for (int c = 0; c < NCH; c++) begin
         if (addr == RA_LIM0 + ADDR_W'(c)) rdata = limit_q[c];
         if (addr == RA_ONT0 + ADDR_W'(c)) rdata = ontime[c];
      end
   end

   assign alert = |(pct_q & ~mask_q);
endmodule

// File: rtl/thermal_duty_monitor.sv
module thermal_duty_monitor
   import tdm_pkg::*;
#(
   parameter int SLOT_TICKS_MIN = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic [TDM_NCH-1:0]     evt_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [VAL_W-1:0]       wdata,
   output logic [VAL_W-1:0]       rdata,
   output logic                   alert
);
   localparam int NCH = TDM_NCH;

   if (SLOT_TICKS_MIN < 1) begin : g_bad_ticks
      $error("SLOT_TICKS_MIN must be at least 1");
   end
   if (CFG_LSB + NCH*CODE_W > VAL_W) begin : g_bad_cfg
      $error("window code fields do not fit the configuration byte");
   end
   if (2*NCH + 1 > 7) begin : g_bad_map
      $error("channel registers overflow the address map");
   end

   logic [NCH-1:0][CODE_W-1:0] code_w;
   logic [NCH-1:0][VAL_W-1:0]  lim_w;
   logic [NCH-1:0][VAL_W-1:0]  cnt_w;
   logic [NCH-1:0][VAL_W-1:0]  ont_w;
   logic [NCH-1:0]             over_w;
   logic [NCH-1:0]             fall_w;
   logic [NCH-1:0]             restart_w;
   logic [NCH-1:0]             slot_end_w;
   logic [NCH-1:0]             win_end_w;
   logic [NCH-1:0]             ev_w;
   logic [NCH-1:0]             pct_w;
   logic [NCH-1:0]             mask_w;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      tdm_slot_timer #(.SLOT_TICKS_MIN(SLOT_TICKS_MIN)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .restart  (restart_w[c]),
         .code     (code_w[c]),
         .slot_end (slot_end_w[c]),
         .win_end  (win_end_w[c])
      );

      tdm_channel_acc u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_n    (evt_n[c]),
         .restart  (restart_w[c]),
         .slot_end (slot_end_w[c]),
         .win_end  (win_end_w[c]),
         .limit    (lim_w[c]),
         .cnt_q    (cnt_w[c]),
         .ont_q    (ont_w[c]),
         .over     (over_w[c]),
         .fall     (fall_w[c])
      );
   end

   tdm_regs #(.NCH(NCH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .ontime  (ont_w),
      .over    (over_w),
      .fall    (fall_w),
      .code_q  (code_w),
      .limit_q (lim_w),
      .restart (restart_w),
      .ev_q    (ev_w),
      .pct_q   (pct_w),
      .mask_q  (mask_w),
      .rdata   (rdata),
      .alert   (alert)
   );
endmodule

// File: rtl/tdm_checker.sv
module tdm_checker
   import tdm_pkg::*;
#(
   parameter int NCH = TDM_NCH
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NCH-1:0]            evt_n,
   input logic                      rd_en,
   input logic [ADDR_W-1:0]         addr,
   input logic                      alert,
   input logic [NCH-1:0][VAL_W-1:0] cnt,
   input logic [NCH-1:0][VAL_W-1:0] lim,
   input logic [NCH-1:0][VAL_W-1:0] ont,
   input logic [NCH-1:0]            ev,
   input logic [NCH-1:0]            pct,
   input logic [NCH-1:0]            mask,
   input logic [NCH-1:0]            restart,
   input logic [NCH-1:0]            over,
   input logic [NCH-1:0]            fall,
   input logic [NCH-1:0]            win_end
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(cnt[c]) |-> ((cnt[c] == $past(cnt[c]) + 8'd1) || (cnt[c] == 8'd0)));

      a_r3_ontime_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(ont[c]) |-> $past(win_end[c]));

      a_r4_rise_needs_excess: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pct[c]) |-> $past(cnt[c] > lim[c]));

      a_r4_full_limit_never_trips: assert property (@(posedge clk) disable iff (!rst_n)
         ((lim[c] == 8'hFF) && !pct[c]) |=> !pct[c]);

      a_r5_fall_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(evt_n[c]) |=> ev[c]);

      a_r8_restart_empties_count: assert property (@(posedge clk) disable iff (!rst_n)
         restart[c] |=> (cnt[c] == 8'd0));
   end

   a_r7_read_leaves_only_new_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == RA_STAT)) |=> ((ev == $past(fall)) && (pct == $past(over))));

   a_r6_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> !alert);
endmodule

bind thermal_duty_monitor tdm_checker #(.NCH(TDM_NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_n   (evt_n),
   .rd_en   (rd_en),
   .addr    (addr),
   .alert   (alert),
   .cnt     (cnt_w),
   .lim     (lim_w),
   .ont     (ont_w),
   .ev      (ev_w),
   .pct     (pct_w),
   .mask    (mask_w),
   .restart (restart_w),
   .over    (over_w),
   .fall    (fall_w),
   .win_end (win_end_w)
);

// File: tb/thermal_duty_monitor_tb.sv
module thermal_duty_monitor_tb;
   localparam int STM      = 1;
   localparam int TICK_DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] evt_n = 2'b11;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   wire  [7:0] rdata;
   wire        alert;

   always #4 clk = ~clk;

   thermal_duty_monitor #(.SLOT_TICKS_MIN(STM)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_n(evt_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .alert(alert)
   );

   // behavioural reference state
   int m_code[2], m_lim[2], m_tc[2], m_si[2], m_cnt[2], m_ont[2];
   bit m_prev[2], m_ev[2], m_pct[2], m_mask[2];
   int checks = 0, fails = 0, cyc = 0;
   int pat[2];
   bit done = 0;
   bit clr, fl, ov, rs;
   int nc, len, n;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic int exp_rd(logic [2:0] a);
      case (a)
         3'd0: return (m_code[1] << 5) | (m_code[0] << 2);
         3'd1: return m_lim[0];
         3'd2: return m_lim[1];
         3'd3: return m_ont[0];
         3'd4: return m_ont[1];
         3'd5: return int'(m_mask[1]) * 2 + int'(m_mask[0]);
         3'd6: return int'(m_pct[1]) * 8 + int'(m_pct[0]) * 4 + int'(m_ev[1]) * 2 + int'(m_ev[0]);
         default: return 0;
      endcase
   endfunction

   function automatic string addr_req(logic [2:0] a);
      case (a)
         3'd0: return "R1";
         3'd1, 3'd2: return "R4";
         3'd3, 3'd4: return "R3";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic logic pat_lvl(int mode, int t, int c);
      case (mode)
         0: return 1'b1;
         1: return 1'b0;
         2: return !(((t / 5) % 3) == 0);
         default: return !(((t / 37) % 2) == c);
      endcase
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_code[c] = 0; m_lim[c] = 255; m_tc[c] = 0; m_si[c] = 0;
            m_cnt[c] = 0; m_ont[c] = 0; m_prev[c] = 1; m_ev[c] = 0;
            m_pct[c] = 0; m_mask[c] = 0;
         end
      end else begin
         clr = rd_en && (addr == 3'd6);
         for (int c = 0; c < 2; c++) begin
            fl = m_prev[c] && !evt_n[c];
            ov = m_cnt[c] > m_lim[c];
            m_ev[c]  = (clr ? 1'b0 : m_ev[c]) | fl;
            m_pct[c] = (clr ? 1'b0 : m_pct[c]) | ov;
            m_prev[c] = evt_n[c];
            nc = (int'(wdata) >> (2 + 3 * c)) & 7;
            rs = wr_en && (addr == 3'd0) && (nc != m_code[c]);
            len = STM << ((m_code[c] > 5) ? 5 : m_code[c]);
            if (rs) begin
               m_tc[c] = 0; m_si[c] = 0; m_cnt[c] = 0;
            end else if (tick) begin
               if (m_tc[c] == len - 1) begin
                  m_tc[c] = 0;
                  n = m_cnt[c] + ((!evt_n[c] && m_cnt[c] < 255) ? 1 : 0);
                  if (m_si[c] == 255) begin
                     m_ont[c] = n; m_cnt[c] = 0; m_si[c] = 0;
                  end else begin
                     m_cnt[c] = n; m_si[c] = m_si[c] + 1;
                  end
               end else begin
                  m_tc[c] = m_tc[c] + 1;
               end
            end
         end
         if (wr_en) begin
            case (addr)
               3'd0: begin
                  m_code[0] = (int'(wdata) >> 2) & 7;
                  m_code[1] = (int'(wdata) >> 5) & 7;
               end
               3'd1: m_lim[0] = int'(wdata);
               3'd2: m_lim[1] = int'(wdata);
               3'd5: begin m_mask[0] = wdata[0]; m_mask[1] = wdata[1]; end
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison, then stimulus for the next edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(addr_req(addr), int'(rdata), exp_rd(addr));
         chk("R6", int'(alert), int'((m_pct[0] && !m_mask[0]) || (m_pct[1] && !m_mask[1])));
      end
      tick = ((cyc % TICK_DIV) == 0);
      for (int c = 0; c < 2; c++) evt_n[c] = pat_lvl(pat[c], cyc, c);
      if (cyc > 190000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk); #1;
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic waitc(int k);
      repeat (k) @(negedge clk);
   endtask

   logic [7:0] v;

   initial begin
      pat[0] = 0; pat[1] = 0;
      waitc(5);
      #1 rst_n = 1'b1;

      // R10: reset values
      chk("R10 alert", int'(alert), 0);
      rd(3'd0, v); chk("R10 cfg", v, 8'h00);
      rd(3'd1, v); chk("R10 lim0", v, 8'hFF);
      rd(3'd2, v); chk("R10 lim1", v, 8'hFF);
      rd(3'd3, v); chk("R10 ont0", v, 8'h00);
      rd(3'd5, v); chk("R10 mask", v, 8'h00);
      rd(3'd6, v); chk("R10 status", v, 8'h00);

      // R9: read-only and unused addresses ignore writes
      wr(3'd3, 8'h5A); wr(3'd6, 8'hA5); wr(3'd7, 8'h3C);
      rd(3'd3, v); chk("R9 ont0", v, 8'h00);
      rd(3'd6, v); chk("R9 status", v, 8'h00);
      rd(3'd7, v); chk("R9 unused", v, 8'h00);

      // R4 / R5: zero limit trips on first asserted sample
      wr(3'd1, 8'h00);
      pat[0] = 1;
      waitc(20);
      chk("R4 alert zero limit", int'(alert), 1);
      rd(3'd6, v);
      chk("R5 event ch0", int'(v[0]), 1);
      chk("R4 pct ch0", int'(v[2]), 1);
      pat[0] = 0;

      // R6: masking both channels silences alert
      wr(3'd5, 8'h03);
      waitc(2);
      chk("R6 masked", int'(alert), 0);
      wr(3'd5, 8'h00);

      // R1 / R8 / R3: ch1 code 1, fully asserted window, limit 0xFF
      pat[1] = 1;
      wr(3'd0, 8'h20);
      rd(3'd0, v); chk("R1 cfg readback", v, 8'h20);
      rd(3'd6, v);
      waitc(2200);
      rd(3'd4, v); chk("R3 ont1 saturated", v, 8'hFF);
      rd(3'd6, v); chk("R4 limit FF never trips", int'(v[3]), 0);

      // R2: ch0 code 2, fully asserted, same ch1 code (R8 no restart)
      pat[0] = 1;
      wr(3'd0, 8'h28);
      waitc(4300);
      rd(3'd3, v); chk("R2 ont0 code2", v, 8'hFF);

      // R7: status reads racing toggling inputs
      pat[0] = 2; pat[1] = 2;
      wr(3'd2, 8'h10);
      for (int i = 0; i < 300; i++) begin
         rd(3'd6, v);
         waitc(i % 3);
      end

      // R8: rewrite of unchanged code mid-window
      wr(3'd0, 8'h28);
      waitc(500);
      wr(3'd0, 8'h28);

      // R2: codes 7 (ch0) and 0 (ch1) with partial patterns
      pat[0] = 3; pat[1] = 2;
      wr(3'd1, 8'h80);
      wr(3'd0, 8'h1C);
      waitc(33200);
      rd(3'd3, v); chk("R2 ont0 code7", v, exp_rd(3'd3));
      rd(3'd4, v); chk("R3 ont1 partial", v, exp_rd(3'd4));

      waitc(10);
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule